// File: doc/BRIEF.md
# Bit-Sliced Sliding-Window Signature Prefilter

This block is the fast first stage of a two-stage content scanner. It takes a byte stream, one character per accepted clock, and keeps the newest `WIN_LEN` characters in a window. The window is cut by bit position into eight lanes. Lane `i` sees only bit `i` of every buffered character, so each lane needs a memory of just `2^WIN_LEN` words. Each lane word is a compressed candidate vector of `VEC_W` bits. Every bit stands for a group of signatures, and a bit is set when any signature in its group has that lane slice.

For each accepted character the block reads all eight lanes and ANDs the eight words together. It then reports the lowest surviving group index with a one-cycle strobe. A second flag marks the case where more than one group survived. Two kinds of signature share a bit: several signatures grouped into one vector bit, and several signatures that each match one lane. Because of this, a window can be flagged when no whole signature is present. A signature that is present is never missed. A downstream exact matcher confirms or rejects each candidate.

Lane contents are written through a plain load port before scanning. The compiler that fills them is a separate tool and is not part of this block.

Top module: `sig_prefilter`

## Requirements
- R1: Each cycle with `char_valid` high shifts `char_in` into the window. Window position 0 holds the newest character and position `WIN_LEN-1` holds the oldest. The window resets to all zero bytes.
- R2: Lane `i` (0..7) is read at an address whose bit `j` is bit `i` of the character at window position `j`. A signature sent first-to-last as bytes s0..s7 gives address bit `j` from byte s(7-j).
- R3: A result is flagged only when the bitwise AND of the eight lane words read for the current window is nonzero.
- R4: `hit_idx` is the lowest set bit position of that AND. When `hit_valid` is low, `hit_idx` and `hit_multi` are zero.
- R5: `hit_multi` is high together with `hit_valid` exactly when two or more bits survive the AND.
- R6: After reset, no result is flagged until `WIN_LEN` characters have been accepted.
- R7: A `restart` pulse restarts the fill count. A character accepted in the same cycle counts as the first of the new stream. The window contents themselves are kept.
- R8: The result for a character accepted at clock edge n appears after edge n+2 and lasts one cycle. Cycles without an accepted character produce no result.
- R9: When `ld_en` is high, `ld_data` is written into lane `ld_lane` at `ld_addr`. A lookup that reads the same word at the same edge gets the old word. Later lookups get the new word.
- R10: A stored signature present in the window is always flagged at its group index or lower. A window built from lane slices of two different signatures in the same group is also flagged, as a false candidate.
- R11: While reset is high, and after it is released, `hit_valid`, `hit_idx` and `hit_multi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Start a new stream (fill count restarts) |
| char_valid | input | 1 | `char_in` is accepted this cycle |
| char_in | input | 8 | Text character |
| ld_en | input | 1 | Lane word write strobe |
| ld_lane | input | 3 | Lane selected for the write |
| ld_addr | input | WIN_LEN (8) | Word address inside the lane |
| ld_data | input | VEC_W (32) | Compressed vector to store |
| hit_valid | output | 1 | Candidate reported this cycle |
| hit_idx | output | $clog2(VEC_W) (5) | Lowest surviving group index |
| hit_multi | output | 1 | More than one group survived |

## Verification
A shifted or misordered window byte, or a swapped lane slice, shows up as a missed stored signature or a wrong index. This appears two edges after the last byte of the window that should have matched. A wrong fill count makes results appear too early after reset or restart, or fail to appear at all. The bench finds this by pushing an all-zero signature straight out of reset and a signature whose last byte arrives with restart. A memory written with the wrong read-write ordering shows up in the single result where a lane word is overwritten at the same edge as its lookup.

// File: rtl/prefilter_pkg.sv
package prefilter_pkg;

    // Text character width; it is also the number of bit lanes.
    localparam int CHAR_W      = 8;
    localparam int LANES       = CHAR_W;
    localparam int DEF_WIN_LEN = 8;
    localparam int DEF_VEC_W   = 32;

    typedef logic [CHAR_W-1:0] char_t;

    // Stages of one lookup, for reference in the pipeline comments.
    typedef enum logic [1:0] {
        STG_SHIFT   = 2'd0,
        STG_READ    = 2'd1,
        STG_RESOLVE = 2'd2
    } stage_e;

endpackage

// File: rtl/pf_window.sv
module pf_window
    import prefilter_pkg::*;
#(
    parameter int WIN_LEN = DEF_WIN_LEN
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              restart,
    input  logic                              char_valid,
    input  char_t                             char_in,
    output logic [LANES-1:0][WIN_LEN-1:0]     lane_addr,
    output logic                              look_vld
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic [WIN_LEN-1:0][CHAR_W-1:0] win_q;
    logic [CNT_W-1:0]               fill_q;
    logic [CNT_W-1:0]               fill_nxt;

    always_comb begin
        if (restart)
            fill_nxt = char_valid ? CNT_W'(1) : '0;
        else if (char_valid && fill_q != CNT_W'(WIN_LEN))
            fill_nxt = fill_q + 1'b1;
        else
            fill_nxt = fill_q;
    end

    // STG_SHIFT: newest character enters at position 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            fill_q   <= '0;
            look_vld <= 1'b0;
        end else begin
            fill_q   <= fill_nxt;
            look_vld <= char_valid && (fill_nxt == CNT_W'(WIN_LEN));
            if (char_valid)
                win_q <= {win_q[WIN_LEN-2:0], char_in};
        end
    end

    // Bit slicing: lane i takes bit i of every window position.
    for (genvar li = 0; li < LANES; li++) begin : g_lane
        for (genvar pj = 0; pj < WIN_LEN; pj++) begin : g_pos
            assign lane_addr[li][pj] = win_q[pj][li];
        end
    end

endmodule

// File: rtl/pf_lane_mem.sv
module pf_lane_mem #(
    parameter int ADDR_W = 8,
    parameter int VEC_W  = 32
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0]  wr_data,
    output logic [VEC_W-1:0]  rd_data
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [VEC_W-1:0] store_q [DEPTH];

    // STG_READ: a read sharing an edge with a write returns the old word.
    always_ff @(posedge clk) begin
        if (wr_en)
            store_q[wr_addr] <= wr_data;
        rd_data <= store_q[rd_addr];
    end

endmodule

// File: rtl/pf_resolve.sv
module pf_resolve
    import prefilter_pkg::*;
#(
    parameter int VEC_W = DEF_VEC_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           vld_in,
    input  logic [LANES-1:0][VEC_W-1:0]    vecs,
    output logic                           hit_valid,
    output logic [$clog2(VEC_W)-1:0]       hit_idx,
    output logic                           hit_multi
);
    localparam int IDX_W = $clog2(VEC_W);

    logic [VEC_W-1:0] and_v;
    logic [IDX_W-1:0] low_idx;
    logic             any_set;
    logic             many_set;

    always_comb begin
        and_v = '1;
        for (int l = 0; l < LANES; l++)
            and_v &= vecs[l];
    end

    always_comb begin
        low_idx = '0;
        for (int b = VEC_W - 1; b >= 0; b--)
            if (and_v[b])
                low_idx = IDX_W'(b);
        any_set  = |and_v;
        many_set = (and_v & (and_v - VEC_W'(1))) != '0;
    end

    // STG_RESOLVE: registered result, zeroed when nothing is reported.
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid <= 1'b0;
            hit_idx   <= '0;
            hit_multi <= 1'b0;
        end else begin
            hit_valid <= vld_in && any_set;
            hit_idx   <= (vld_in && any_set) ? low_idx : '0;
            hit_multi <= vld_in && many_set;
        end
    end

endmodule

// File: rtl/sig_prefilter.sv
module sig_prefilter
    import prefilter_pkg::*;
#(
    parameter int WIN_LEN = DEF_WIN_LEN,
    parameter int VEC_W   = DEF_VEC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart,
    input  logic                     char_valid,
    input  logic [7:0]               char_in,
    input  logic                     ld_en,
    input  logic [2:0]               ld_lane,
    input  logic [WIN_LEN-1:0]       ld_addr,
    input  logic [VEC_W-1:0]         ld_data,
    output logic                     hit_valid,
    output logic [$clog2(VEC_W)-1:0] hit_idx,
    output logic                     hit_multi
);
    localparam int LANE_SEL_W = $clog2(LANES);

    logic [LANES-1:0][WIN_LEN-1:0] lane_addr;
    logic [LANES-1:0][VEC_W-1:0]   lane_vec;
    logic                          look_vld;
    logic                          read_vld;

    pf_window #(.WIN_LEN(WIN_LEN)) u_win (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .char_valid (char_valid),
        .char_in    (char_in),
        .lane_addr  (lane_addr),
        .look_vld   (look_vld)
    );

    for (genvar li = 0; li < LANES; li++) begin : g_mem
        logic wr_sel;
        assign wr_sel = ld_en && (ld_lane == LANE_SEL_W'(li));

        pf_lane_mem #(.ADDR_W(WIN_LEN), .VEC_W(VEC_W)) u_mem (
            .clk     (clk),
            .rd_addr (lane_addr[li]),
            .wr_en   (wr_sel),
            .wr_addr (ld_addr),
            .wr_data (ld_data),
            .rd_data (lane_vec[li])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            read_vld <= 1'b0;
        else
            read_vld <= look_vld;
    end

    pf_resolve #(.VEC_W(VEC_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .vld_in    (read_vld),
        .vecs      (lane_vec),
        .hit_valid (hit_valid),
        .hit_idx   (hit_idx),
        .hit_multi (hit_multi)
    );

endmodule

// File: rtl/sig_prefilter_chk.sv
module sig_prefilter_chk #(
    parameter int WIN_LEN = 8,
    parameter int VEC_W   = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     restart,
    input logic                     char_valid,
    input logic                     hit_valid,
    input logic [$clog2(VEC_W)-1:0] hit_idx,
    input logic                     hit_multi
);
    int   seen_q;
    int   seen_n;
    logic full0_q, full1_q, full2_q;

    always_comb begin
        if (restart)
            seen_n = char_valid ? 1 : 0;
        else if (char_valid && seen_q < WIN_LEN)
            seen_n = seen_q + 1;
        else
            seen_n = seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 0;
            full0_q <= 1'b0;
            full1_q <= 1'b0;
            full2_q <= 1'b0;
        end else begin
            seen_q  <= seen_n;
            full0_q <= char_valid && (seen_n >= WIN_LEN);
            full1_q <= full0_q;
            full2_q <= full1_q;
        end
    end

    // R6
    warmup_gate_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> full2_q);

    // R8
    latency_src_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> $past(char_valid, 3));

    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> (hit_idx == '0 && !hit_multi));

    // R5
    multi_qual_chk: assert property (@(posedge clk) disable iff (rst)
        hit_multi |-> hit_valid);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!hit_valid && !hit_multi));

endmodule

bind sig_prefilter sig_prefilter_chk #(.WIN_LEN(WIN_LEN), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .char_valid (char_valid),
    .hit_valid  (hit_valid),
    .hit_idx    (hit_idx),
    .hit_multi  (hit_multi)
);

// File: tb/sim_sig_prefilter.sv
module sim_sig_prefilter;
    localparam int WL = 8;
    localparam int VW = 32;
    localparam int IW = $clog2(VW);

    // Signature table: byte [63:56] is sent first.
    localparam int NPAT = 7;
    localparam logic [63:0] PAT [NPAT] = '{
        "ATTACK01", "DROPPER!", "KEYLOG99", "BACKDOOR",
        "WORMWORM", "WORMWORM", 64'h0
    };
    localparam int PAT_GRP [NPAT] = '{3, 3, 0, 31, 9, 20, 5};

    // Scan vectors and the group that must be reported at or below (-1: model only).
    localparam int NSCAN = 7;
    localparam logic [63:0] SCAN [NSCAN] = '{
        "ATTACK01", "HELLOWLD", "DROPPER!", "KEYLOG99",
        "NOTAVIRS", "BACKDOOR", "WORMWORM"
    };
    localparam int SCAN_GRP [NSCAN] = '{3, -1, 3, 0, -1, 31, 9};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          restart = 1'b0;
    logic          char_valid = 1'b0;
    logic [7:0]    char_in = '0;
    logic          ld_en = 1'b0;
    logic [2:0]    ld_lane = '0;
    logic [WL-1:0] ld_addr = '0;
    logic [VW-1:0] ld_data = '0;
    logic          hit_valid;
    logic [IW-1:0] hit_idx;
    logic          hit_multi;

    always #10 clk = ~clk;

    sig_prefilter #(.WIN_LEN(WL), .VEC_W(VW)) u0 (
        .clk(clk), .rst(rst), .restart(restart), .char_valid(char_valid),
        .char_in(char_in), .ld_en(ld_en), .ld_lane(ld_lane), .ld_addr(ld_addr),
        .ld_data(ld_data), .hit_valid(hit_valid), .hit_idx(hit_idx),
        .hit_multi(hit_multi)
    );

    int            n_chk = 0;
    int            n_bad = 0;
    logic [VW-1:0] shadow [8][256];
    logic [7:0]    bwin [WL];
    int            bfill = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model(output bit v, output int idx, output bit mul);
        logic [VW-1:0] acc;
        logic [WL-1:0] a;
        acc = '1;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < WL; j++) a[j] = bwin[j][i];
            acc &= shadow[i][a];
        end
        v = (bfill == WL) && (acc != '0);
        idx = 0;
        if (v) for (int b = VW - 1; b >= 0; b--) if (acc[b]) idx = b;
        mul = v && ($countones(acc) > 1);
    endtask

    task automatic model_shift(input logic [7:0] ch, input bit rs);
        if (rs) bfill = 1;
        else if (bfill < WL) bfill++;
        for (int j = WL - 1; j > 0; j--) bwin[j] = bwin[j-1];
        bwin[0] = ch;
    endtask

    task automatic compare(input bit ev, input int ei, input bit em, input string req);
        bit ok;
        ok = (hit_valid == ev) && (hit_idx == IW'(ei)) && (hit_multi == em);
        check(ok, req, "valid/multi/idx", {hit_valid, hit_multi, 8'(hit_idx)},
              {ev, em, 8'(ei)});
    endtask

    task automatic push(input logic [7:0] ch, input bit rs, input string req);
        bit ev; int ei; bit em;
        @(negedge clk);
        char_valid = 1'b1; char_in = ch; restart = rs;
        model_shift(ch, rs);
        model(ev, ei, em);
        @(posedge clk); #1;
        char_valid = 1'b0; restart = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        compare(ev, ei, em, req);
    endtask

    task automatic send(input logic [63:0] p, input string req);
        for (int k = 0; k < 8; k++) push(p[8*(7-k) +: 8], 1'b0, req);
    endtask

    task automatic wr(input int lane, input logic [WL-1:0] addr, input logic [VW-1:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_lane = 3'(lane); ld_addr = addr; ld_data = data;
        shadow[lane][addr] = data;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    function automatic logic [WL-1:0] slice(input logic [63:0] p, input int lane);
        logic [WL-1:0] a;
        for (int j = 0; j < WL; j++) a[j] = p[8*j + lane];
        return a;
    endfunction

    task automatic store(input logic [63:0] p, input int g);
        for (int i = 0; i < 8; i++)
            wr(i, slice(p, i), shadow[i][slice(p, i)] | (VW'(1) << g));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        rst = 1'b0;
        bfill = 0;
        for (int j = 0; j < WL; j++) bwin[j] = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ev [8]; int ei [8]; bit em [8];
        logic [63:0] fp;
        logic [WL-1:0] a0;

        // R11: outputs quiet during and after reset
        for (int j = 0; j < WL; j++) bwin[j] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!hit_valid && hit_idx == 0 && !hit_multi, "R11", "during reset",
              {hit_valid, hit_multi, 8'(hit_idx)}, 0);
        do_reset();
        @(negedge clk);
        check(!hit_valid && hit_idx == 0 && !hit_multi, "R11", "after reset",
              {hit_valid, hit_multi, 8'(hit_idx)}, 0);

        // R9: load all lanes, then the signature table
        for (int i = 0; i < 8; i++)
            for (int a = 0; a < 256; a++) wr(i, WL'(a), '0);
        for (int p = 0; p < NPAT; p++) store(PAT[p], PAT_GRP[p]);

        // R6: all-zero signature stays silent until the window is full
        do_reset();
        for (int k = 0; k < WL - 1; k++) begin
            push(8'h00, 1'b0, "R6");
            check(!hit_valid, "R6", "early hit", hit_valid, 0);
        end
        push(8'h00, 1'b0, "R6");
        check(hit_valid && hit_idx == 5, "R6", "full zero window",
              {hit_valid, 8'(hit_idx)}, {1'b1, 8'd5});

        // R1 R2 R3 R4: table-driven scan
        for (int s = 0; s < NSCAN; s++) begin
            send(SCAN[s], "R3");
            if (SCAN_GRP[s] >= 0)
                check(hit_valid && int'(hit_idx) <= SCAN_GRP[s], "R10", "stored signature",
                      {hit_valid, 8'(hit_idx)}, {1'b1, 8'(SCAN_GRP[s])});
        end

        // R5: duplicated signature in groups 9 and 20
        send("WORMWORM", "R5");
        check(hit_valid && hit_multi && int'(hit_idx) <= 9, "R5", "multi group",
              {hit_valid, hit_multi, 8'(hit_idx)}, {1'b1, 1'b1, 8'd9});

        // R2 R4: top group 31
        send("BACKDOOR", "R4");
        check(hit_valid && !hit_multi && hit_idx == 31, "R2", "group 31 slice",
              {hit_valid, hit_multi, 8'(hit_idx)}, {1'b1, 1'b0, 8'd31});

        // R10: low nibbles of one group-3 signature, high nibbles of the other
        for (int j = 0; j < 8; j++)
            fp[8*j +: 8] = (PAT[0][8*j +: 8] & 8'h0F) | (PAT[1][8*j +: 8] & 8'hF0);
        send(fp, "R10");
        check(hit_valid && int'(hit_idx) <= 3, "R10", "false candidate",
              {hit_valid, 8'(hit_idx)}, {1'b1, 8'd3});

        // R8: back-to-back characters, one result per character, two edges late
        for (int k = 0; k <= 10; k++) begin
            @(negedge clk);
            if (k >= 3) compare(ev[k-3], ei[k-3], em[k-3], "R8");
            if (k < 8) begin
                char_valid = 1'b1; char_in = PAT[2][8*(7-k) +: 8];
                model_shift(char_in, 1'b0);
                model(ev[k], ei[k], em[k]);
            end else begin
                char_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(!hit_valid, "R8", "no result without character", hit_valid, 0);

        // R7: last byte arrives with restart -> fill restarts, no result
        for (int k = 0; k < 7; k++) push(PAT[0][8*(7-k) +: 8], 1'b0, "R7");
        push(PAT[0][7:0], 1'b1, "R7");
        check(!hit_valid, "R7", "restart suppresses", hit_valid, 0);
        // R7: restart alone, then a full signature is reported on its last byte
        @(negedge clk); restart = 1'b1;
        @(posedge clk); #1; restart = 1'b0;
        bfill = 0;
        send(PAT[0], "R7");
        check(hit_valid && int'(hit_idx) <= 3, "R7", "after restart",
              {hit_valid, 8'(hit_idx)}, {1'b1, 8'd3});

        // R9: overwrite lane 0 word at the same edge as its lookup
        a0 = slice(PAT[0], 0);
        for (int k = 0; k < 7; k++) push(PAT[0][8*(7-k) +: 8], 1'b0, "R9");
        @(negedge clk);
        char_valid = 1'b1; char_in = PAT[0][7:0];
        model_shift(char_in, 1'b0);
        model(ev[0], ei[0], em[0]);
        @(posedge clk); #1;
        char_valid = 1'b0;
        ld_en = 1'b1; ld_lane = 3'd0; ld_addr = a0; ld_data = '0;
        @(posedge clk); #1;
        ld_en = 1'b0;
        shadow[0][a0] = '0;
        @(posedge clk);
        @(negedge clk);
        compare(ev[0], ei[0], em[0], "R9");
        check(hit_valid, "R9", "old word on same-edge read", hit_valid, 1);
        send(PAT[0], "R9");
        check(!hit_valid, "R9", "new word after write", hit_valid, 0);
        store(PAT[0], 3);
        store(PAT[1], 3);
        send(PAT[0], "R9");
        check(hit_valid && int'(hit_idx) <= 3, "R9", "restored word",
              {hit_valid, 8'(hit_idx)}, {1'b1, 8'd3});

        finish_run();
    end

endmodule